// File: doc/BRIEF.md
# Dual-Period Watchdog Pair

This block holds two independent watchdog timers. Each timer has two timeout lengths: a long initial period and a normal period. The initial period runs after the timer is enabled and again after every expiry. The normal period takes over once the timer sees its first clear. A clear is a rising edge on a selected source. The source is one general-purpose input, one fed-back supervisory output, or either of the two.

When a period runs out, the timer raises its timeout flag for exactly one base tick. It then reloads the initial period. A per-timer routing mask sends each flag to any set of supervisory output requests. Each request is the OR of the flags routed to it.

Time is counted in base ticks of `TICK_CLKS` clock cycles. A timeout code c selects a period of 2^c ticks. Codes run from 0 to 14, and any larger code acts as 14.

Each timer runs a four-state machine:
- IDLE: disabled. The counters are held at zero and the flag is low.
- INIT: the initial period is running.
- NORM: the normal period is running.
- EXPIRE: the flag is high for one tick.

The transitions are:
- IDLE→INIT on enable.
- INIT→NORM and NORM→NORM on a clear. Each of these restarts the count.
- INIT→EXPIRE and NORM→EXPIRE when the period ends.
- EXPIRE→INIT after one tick.
- Any state goes to IDLE when enable is low.

Top module: `wdg_pair`

## Requirements
- R1: While in reset, and in any cycle after a clock edge that sampled `enable[i]` low, `timeout[i]` is 0. A disabled timer never expires.
- R2: After `enable[i]` is first sampled high, `timeout[i]` rises exactly 2^init_code × TICK_CLKS cycles later. The clock edge that first samples enable high is counted as edge 0.
- R3: A clear seen in INIT or NORM restarts the count with the normal period. `timeout[i]` then rises exactly 2^norm_code × TICK_CLKS cycles after the clearing edge. Clears that repeat faster than that keep the flag low.
- R4: The flag stays high for exactly TICK_CLKS cycles. The next expiry then comes one full initial period after the flag falls.
- R5: The clear-mode code sits in bits [2i+1:2i] of `clr_mode`. With code 0, only a rising edge of `gpi[gpi_sel_i]` clears. Edges on the fed-back outputs and on other inputs have no effect.
- R6: With clear-mode code 1, only a rising edge of `po_fb[po_sel_i]` clears. Input edges have no effect.
- R7: With clear-mode code 2 or 3, a rising edge on either the selected input or the selected output clears.
- R8: Only rising edges clear. Holding the source high gives a single clear, and its falling edge has no effect.
- R9: Timeout codes above 14 behave as code 14, which is 16384 ticks.
- R10: `sup_assert[j]` is high whenever some timer i has `timeout[i]` high and route bit `route_mask[i*NUM_PO+j]` set. It is low when no such timer exists.
- R11: The two timers run independently, each on its own codes and its own enable.
- R12: Dropping enable in mid-period, or while the flag is high, lowers the flag on the next edge. Enabling again restarts a full initial period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | NUM_WDG | Per-timer enable |
| clr_mode | input | 2*NUM_WDG | Per-timer clear-source code (0 input, 1 output, 2/3 either) |
| gpi_sel | input | NUM_WDG*$clog2(NUM_GPI) | Per-timer index of the clearing input |
| po_sel | input | NUM_WDG*$clog2(NUM_PO) | Per-timer index of the clearing output |
| init_code | input | NUM_WDG*CODE_W | Per-timer initial timeout code |
| norm_code | input | NUM_WDG*CODE_W | Per-timer normal timeout code |
| gpi | input | NUM_GPI | General-purpose inputs |
| po_fb | input | NUM_PO | Supervisory output states fed back |
| route_mask | input | NUM_WDG*NUM_PO | Per-timer set of outputs its flag asserts |
| timeout | output | NUM_WDG | Per-timer expiry flag |
| sup_assert | output | NUM_PO | Assert requests toward the output stages |

## Verification
Each internal fault shows up at the ports within one period.
- A counter or prescaler that slips by one moves the rising edge of `timeout` off its predicted cycle. The bench samples on both sides of each rising and falling edge, so the slip is caught on the first expiry.
- A state machine left in the wrong state picks the wrong period. For example, staying in INIT after a clear shows up as a late expiry, one initial period after the clear instead of one normal period.
- A broken edge detector shows either a premature normal-length expiry, or an expiry that comes when it should have been suppressed.
- A wrong routing bit shows on `sup_assert` in the same cycle the flag rises.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Largest timeout code honoured; larger codes saturate here.
    localparam int MAX_CODE = 14;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INIT   = 2'd1,
        ST_NORM   = 2'd2,
        ST_EXPIRE = 2'd3
    } wdg_state_e;

    typedef enum logic [1:0] {
        CLR_GPI   = 2'd0,
        CLR_PO    = 2'd1,
        CLR_BOTH  = 2'd2,
        CLR_BOTH2 = 2'd3
    } clr_mode_e;

endpackage

// File: rtl/wdg_clear_sel.sv
module wdg_clear_sel
    import wdg_pkg::*;
#(
    parameter int NUM_GPI = 4,
    parameter int NUM_PO  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_GPI-1:0]         gpi,
    input  logic [NUM_PO-1:0]          po_fb,
    input  logic [$clog2(NUM_GPI)-1:0] gsel,
    input  logic [$clog2(NUM_PO)-1:0]  psel,
    input  logic [1:0]                 mode,
    output logic                       clr
);

    logic g_now, p_now;
    logic g_q, p_q;
    logic g_rise, p_rise;

    assign g_now = gpi[gsel];
    assign p_now = po_fb[psel];

    // The previous values are tracked every cycle, so a level that is already
    // high at enable is never taken as a clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= 1'b0;
            p_q <= 1'b0;
        end else begin
            g_q <= g_now;
            p_q <= p_now;
        end
    end

    assign g_rise = g_now & ~g_q;
    assign p_rise = p_now & ~p_q;

    always_comb begin
        unique case (clr_mode_e'(mode))
            CLR_GPI:   clr = g_rise;
            CLR_PO:    clr = p_rise;
            CLR_BOTH:  clr = g_rise | p_rise;
            CLR_BOTH2: clr = g_rise | p_rise;
            default:   clr = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int TICK_CLKS = 4,
    parameter int CODE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic [CODE_W-1:0] init_code,
    input  logic [CODE_W-1:0] norm_code,
    output logic              timeout
);

    localparam int PRE_W = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam int CNT_W = MAX_CODE + 1;

    wdg_state_e        state_q, state_d;
    logic [PRE_W-1:0]  pre_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              tick;
    logic              period_done;
    logic              restart;
    logic [CNT_W-1:0]  last_idx;
    logic [CODE_W-1:0] cur_code;

    function automatic int unsigned clamp_code(input logic [CODE_W-1:0] c);
        if (int'(c) > MAX_CODE)
            return MAX_CODE;
        return int'(c);
    endfunction

    assign tick = (pre_q == PRE_W'(TICK_CLKS - 1));

    // Period length: the normal code once a clear has been seen, else initial.
    always_comb begin
        cur_code = (state_q == ST_NORM) ? norm_code : init_code;
        last_idx = (CNT_W'(1) << clamp_code(cur_code)) - CNT_W'(1);
    end

    assign period_done = tick && (cnt_q == last_idx);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en)
                    state_d = ST_INIT;
            end
            ST_INIT, ST_NORM: begin
                if (clr)
                    state_d = ST_NORM;
                else if (period_done)
                    state_d = ST_EXPIRE;
            end
            ST_EXPIRE: begin
                if (tick)
                    state_d = ST_INIT;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!en)
            state_d = ST_IDLE;
    end

    // A clear while counting, or any change of state, restarts both counters.
    assign restart = (clr && (state_q == ST_INIT || state_q == ST_NORM)) ||
                     (state_d != state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (state_q == ST_IDLE || state_d == ST_IDLE || restart) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // Output logic.
    always_comb begin
        unique case (state_q)
            ST_EXPIRE: timeout = 1'b1;
            default:   timeout = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdg_route.sv
module wdg_route #(
    parameter int NUM_WDG = 2,
    parameter int NUM_PO  = 8
) (
    input  logic [NUM_WDG-1:0]        flags,
    input  logic [NUM_WDG*NUM_PO-1:0] mask,
    output logic [NUM_PO-1:0]         req
);

    for (genvar j = 0; j < NUM_PO; j++) begin : g_out
        logic [NUM_WDG-1:0] hits;
        for (genvar i = 0; i < NUM_WDG; i++) begin : g_src
            assign hits[i] = flags[i] & mask[i*NUM_PO + j];
        end
        assign req[j] = |hits;
    end

endmodule

// File: rtl/wdg_pair.sv
module wdg_pair
    import wdg_pkg::*;
#(
    parameter int NUM_WDG   = 2,
    parameter int NUM_GPI   = 4,
    parameter int NUM_PO    = 8,
    parameter int TICK_CLKS = 4,
    parameter int CODE_W    = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_WDG-1:0]                 enable,
    input  logic [2*NUM_WDG-1:0]               clr_mode,
    input  logic [NUM_WDG*$clog2(NUM_GPI)-1:0] gpi_sel,
    input  logic [NUM_WDG*$clog2(NUM_PO)-1:0]  po_sel,
    input  logic [NUM_WDG*CODE_W-1:0]          init_code,
    input  logic [NUM_WDG*CODE_W-1:0]          norm_code,
    input  logic [NUM_GPI-1:0]                 gpi,
    input  logic [NUM_PO-1:0]                  po_fb,
    input  logic [NUM_WDG*NUM_PO-1:0]          route_mask,
    output logic [NUM_WDG-1:0]                 timeout,
    output logic [NUM_PO-1:0]                  sup_assert
);

    localparam int GS_W = $clog2(NUM_GPI);
    localparam int PS_W = $clog2(NUM_PO);

    logic [NUM_WDG-1:0] clr;

    for (genvar i = 0; i < NUM_WDG; i++) begin : g_wdg
        wdg_clear_sel #(
            .NUM_GPI (NUM_GPI),
            .NUM_PO  (NUM_PO)
        ) u_clr (
            .clk   (clk),
            .rst_n (rst_n),
            .gpi   (gpi),
            .po_fb (po_fb),
            .gsel  (gpi_sel[i*GS_W +: GS_W]),
            .psel  (po_sel[i*PS_W +: PS_W]),
            .mode  (clr_mode[2*i +: 2]),
            .clr   (clr[i])
        );

        wdg_timer #(
            .TICK_CLKS (TICK_CLKS),
            .CODE_W    (CODE_W)
        ) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (enable[i]),
            .clr       (clr[i]),
            .init_code (init_code[i*CODE_W +: CODE_W]),
            .norm_code (norm_code[i*CODE_W +: CODE_W]),
            .timeout   (timeout[i])
        );
    end

    wdg_route #(
        .NUM_WDG (NUM_WDG),
        .NUM_PO  (NUM_PO)
    ) u_route (
        .flags (timeout),
        .mask  (route_mask),
        .req   (sup_assert)
    );

endmodule

// File: rtl/wdg_pair_chk.sv
module wdg_pair_chk #(
    parameter int NUM_WDG   = 2,
    parameter int NUM_PO    = 8,
    parameter int TICK_CLKS = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_WDG-1:0]          enable,
    input logic [NUM_WDG*NUM_PO-1:0]   route_mask,
    input logic [NUM_WDG-1:0]          timeout,
    input logic [NUM_PO-1:0]           sup_assert
);

    for (genvar i = 0; i < NUM_WDG; i++) begin : g_ch
        int unsigned hi_len;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                hi_len <= 0;
            else if (timeout[i])
                hi_len <= hi_len + 1;
            else
                hi_len <= 0;
        end

        // R1: a disabled timer shows no flag after the edge.
        p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !enable[i] |=> !timeout[i]);

        // R4: the flag never lasts longer than one tick.
        p_flag_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
            hi_len <= TICK_CLKS);

        // R4: a flag that ends while the timer is enabled lasted a full tick.
        p_flag_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(timeout[i]) && $past(enable[i])) |-> (hi_len == TICK_CLKS));

        for (genvar j = 0; j < NUM_PO; j++) begin : g_po
            // R10: a routed flag reaches its output request.
            p_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (timeout[i] && route_mask[i*NUM_PO + j]) |-> sup_assert[j]);
        end
    end

endmodule

bind wdg_pair wdg_pair_chk #(
    .NUM_WDG   (NUM_WDG),
    .NUM_PO    (NUM_PO),
    .TICK_CLKS (TICK_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .route_mask (route_mask),
    .timeout    (timeout),
    .sup_assert (sup_assert)
);

// File: tb/wdg_pair_bench.sv
module wdg_pair_bench;

    localparam int NW = 2;
    localparam int NG = 4;
    localparam int NP = 8;
    localparam int TK = 4;
    localparam int CW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic [NW-1:0]     enable;
    logic [2*NW-1:0]   clr_mode;
    logic [NW*2-1:0]   gpi_sel;
    logic [NW*3-1:0]   po_sel;
    logic [NW*CW-1:0]  init_code;
    logic [NW*CW-1:0]  norm_code;
    logic [NG-1:0]     gpi;
    logic [NP-1:0]     po_fb;
    logic [NW*NP-1:0]  route_mask;
    logic [NW-1:0]     timeout;
    logic [NP-1:0]     sup_assert;

    wdg_pair #(
        .NUM_WDG (NW), .NUM_GPI (NG), .NUM_PO (NP), .TICK_CLKS (TK), .CODE_W (CW)
    ) u_wdg_pair (
        .clk (clk), .rst_n (rst_n), .enable (enable), .clr_mode (clr_mode),
        .gpi_sel (gpi_sel), .po_sel (po_sel), .init_code (init_code),
        .norm_code (norm_code), .gpi (gpi), .po_fb (po_fb),
        .route_mask (route_mask), .timeout (timeout), .sup_assert (sup_assert)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Rising edge of the flag expected on relative edge n (next edge is 0).
    task automatic wait_rise(input int ch, input int n, input string tag);
        clk_n(n);
        chk({tag, " before rise"}, 32'(timeout[ch]), 32'd0);
        clk_n(1);
        chk({tag, " rise"}, 32'(timeout[ch]), 32'd1);
    endtask

    // Called right after a rise: the flag must last exactly TK cycles.
    task automatic wait_fall(input int ch, input string tag);
        clk_n(TK - 1);
        chk({tag, " flag held"}, 32'(timeout[ch]), 32'd1);
        clk_n(1);
        chk({tag, " flag fell"}, 32'(timeout[ch]), 32'd0);
    endtask

    task automatic pulse_gpi(input int idx);
        gpi[idx] = 1'b1;
        clk_n(1);
        gpi[idx] = 1'b0;
    endtask

    task automatic pulse_po(input int idx);
        po_fb[idx] = 1'b1;
        clk_n(1);
        po_fb[idx] = 1'b0;
    endtask

    task automatic set_ch(input int ch, input int mode, input int gs, input int ps,
                          input int ic, input int nc);
        clr_mode[ch*2 +: 2]    = 2'(mode);
        gpi_sel[ch*2 +: 2]     = 2'(gs);
        po_sel[ch*3 +: 3]      = 3'(ps);
        init_code[ch*CW +: CW] = CW'(ic);
        norm_code[ch*CW +: CW] = CW'(nc);
    endtask

    task automatic idle_all();
        enable = '0;
        gpi    = '0;
        po_fb  = '0;
        clk_n(2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        clk_n(3);
        chk("R1 reset timeout", 32'(timeout), 32'd0);
        chk("R1 reset sup", 32'(sup_assert), 32'd0);
        rst_n = 1'b1;
        set_ch(0, 0, 1, 0, 0, 0);
        clk_n(50);
        chk("R1 disabled no expiry", 32'(timeout), 32'd0);
    endtask

    task automatic t_initial();
        set_ch(0, 0, 1, 0, 2, 1);
        enable[0] = 1'b1;
        wait_rise(0, 16, "R2 initial");
        chk("R10 route ch0", 32'(sup_assert), 32'h21);
        wait_fall(0, "R4");
        wait_rise(0, 15, "R4 reload initial");
        idle_all();
    endtask

    task automatic t_normal();
        set_ch(0, 0, 1, 0, 3, 1);
        enable[0] = 1'b1;
        clk_n(10);
        pulse_gpi(1);
        wait_rise(0, 7, "R3 normal");
        wait_fall(0, "R4");
        wait_rise(0, 31, "R4 initial after expiry");
        idle_all();
        enable[0] = 1'b1;
        clk_n(3);
        pulse_gpi(1);
        for (int k = 0; k < 6; k++) begin
            clk_n(4);
            chk("R3 clears keep flag low", 32'(timeout[0]), 32'd0);
            pulse_gpi(1);
        end
        wait_rise(0, 7, "R3 after last clear");
        idle_all();
    endtask

    task automatic t_gpi_only();
        set_ch(0, 0, 1, 2, 2, 0);
        enable[0] = 1'b1;
        clk_n(5);
        pulse_po(2);
        pulse_gpi(0);
        wait_rise(0, 9, "R5 other edges ignored");
        idle_all();
    endtask

    task automatic t_po_only();
        set_ch(0, 1, 1, 2, 3, 0);
        enable[0] = 1'b1;
        clk_n(5);
        pulse_gpi(1);
        wait_rise(0, 26, "R6 gpi ignored");
        wait_fall(0, "R6");
        pulse_po(2);
        wait_rise(0, 3, "R6 po clear");
        idle_all();
    endtask

    task automatic t_both();
        set_ch(0, 2, 1, 2, 3, 1);
        enable[0] = 1'b1;
        clk_n(3);
        pulse_gpi(1);
        clk_n(4);
        chk("R7 mode2 no flag", 32'(timeout[0]), 32'd0);
        pulse_po(2);
        wait_rise(0, 7, "R7 mode2");
        idle_all();
        set_ch(0, 3, 1, 2, 3, 1);
        enable[0] = 1'b1;
        clk_n(3);
        pulse_po(2);
        clk_n(4);
        chk("R7 mode3 no flag", 32'(timeout[0]), 32'd0);
        pulse_gpi(1);
        wait_rise(0, 7, "R7 mode3");
        idle_all();
    endtask

    task automatic t_level();
        set_ch(0, 0, 1, 0, 3, 1);
        enable[0] = 1'b1;
        clk_n(4);
        gpi[1] = 1'b1;
        clk_n(1);
        wait_rise(0, 7, "R8 held level one clear");
        wait_fall(0, "R8");
        gpi[1] = 1'b0;
        wait_rise(0, 31, "R8 falling edge ignored");
        idle_all();
    endtask

    task automatic t_indep();
        set_ch(0, 0, 0, 0, 2, 0);
        set_ch(1, 0, 0, 0, 1, 0);
        enable = 2'b11;
        wait_rise(1, 8, "R11 ch1");
        chk("R11 ch0 unaffected", 32'(timeout[0]), 32'd0);
        chk("R10 route ch1", 32'(sup_assert), 32'hA0);
        wait_rise(0, 7, "R11 ch0");
        chk("R10 route ch0 only", 32'(sup_assert), 32'h21);
        idle_all();
    endtask

    task automatic t_disable();
        set_ch(0, 0, 0, 0, 2, 0);
        enable[0] = 1'b1;
        clk_n(10);
        enable[0] = 1'b0;
        clk_n(1);
        chk("R12 disabled", 32'(timeout[0]), 32'd0);
        clk_n(20);
        chk("R1 no expiry while disabled", 32'(timeout[0]), 32'd0);
        enable[0] = 1'b1;
        wait_rise(0, 16, "R12 full restart");
        enable[0] = 1'b0;
        clk_n(1);
        chk("R12 flag dropped", 32'(timeout[0]), 32'd0);
        idle_all();
    endtask

    task automatic t_clamp();
        set_ch(0, 0, 0, 0, 15, 0);
        enable[0] = 1'b1;
        wait_rise(0, 65536, "R9 clamp");
        idle_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        rst_n      = 1'b0;
        enable     = '0;
        clr_mode   = '0;
        gpi_sel    = '0;
        po_sel     = '0;
        init_code  = '0;
        norm_code  = '0;
        gpi        = '0;
        po_fb      = '0;
        route_mask = {8'hA0, 8'h21};
        t_reset();
        t_initial();
        t_normal();
        t_gpi_only();
        t_po_only();
        t_both();
        t_level();
        t_indep();
        t_disable();
        t_clamp();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

endmodule